// File: doc/BRIEF.md
# Comparator Control and Interrupt Wrapper

This block is the digital shell around an analog voltage comparator. The raw comparator decision enters as one asynchronous bit. The block passes it through a synchronizer and shows it in an 8-bit control and status register. The register is reached over a plain single-register write strobe and read port. The block watches the synchronized decision for the edge type that software selects. A matching edge sets a sticky flag. The flag, a local enable and a global enable input together form the interrupt request.

The block also produces the digital steering for the analog front end:
- a power enable for the comparator;
- a select that replaces the positive pin with the internal reference;
- a pin-change suppression for the two comparator pins;
- the negative-input steering, which is either the dedicated pin or one converter channel.

The converter channel is taken from an external converter mux field. It is used only while the mux-enable bit is set and the converter is switched off. A new selector value reaches the steering outputs one clock after it is presented.

Top module: `cmp_ctl_top`

## Requirements
- R1: After reset, every writable register bit reads 0, `irq_o` is 0, `neg_use_pin_o` is 1, `neg_ch_valid_o` is 0 and `neg_ch_o` is 0.
- R2: The register image reads {off[7], refsel[6], cmp_out[5], flag[4], ie[3], mux_en[2], mode[1:0]}. A write loads bits 7, 6, 3, 2, 1 and 0. Bit 5 is read-only and shows the comparator input after SYNC_STAGES clock edges.
- R3: With mode 00 any change of the synchronized input sets the flag. With mode 10 only a 1-to-0 change sets it, and with mode 11 only a 0-to-1 change sets it. A change of `cmp_raw_i` first reads as a set flag after the third rising clock edge.
- R4: With mode 01 (reserved) the flag never becomes set.
- R5: The flag clears on `irq_ack_i` or on a write with bit 4 set. A write with bit 4 clear leaves the flag unchanged.
- R6: If a flag-setting edge and a clear request fall in the same cycle, the flag ends set.
- R7: `irq_o` is 1 exactly when the flag, ie (bit 3) and `gie_i` are all 1.
- R8: `pos_sel_ref_o` equals register bit 6.
- R9: When mux_en (bit 2) is 1 and `adc_en_i` is 0, codes 0 to NUM_CH-1 of `adc_mux_i[3:0]` drive `neg_ch_o` with `neg_ch_valid_o`=1 and `neg_use_pin_o`=0. In every other case `neg_use_pin_o` is 1, `neg_ch_valid_o` is 0 and `neg_ch_o` is 0. `adc_mux_i[4]` has no effect.
- R10: On the channel path, selector codes NUM_CH to 15 give `neg_ch_o`=0, `neg_ch_valid_o`=0 and `neg_use_pin_o`=0.
- R11: A change of `adc_mux_i[3:0]` shows on the negative steering outputs after the next rising clock edge, and not before it.
- R12: `cmp_pwr_en_o` and `pin_chg_dis_o` both equal the inverse of register bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read image |
| cmp_raw_i | input | 1 | Raw asynchronous comparator decision |
| irq_ack_i | input | 1 | Interrupt acknowledge pulse |
| gie_i | input | 1 | Global interrupt enable |
| irq_o | output | 1 | Interrupt request |
| adc_en_i | input | 1 | Converter enabled |
| adc_mux_i | input | 5 | Converter mux field, low 4 bits used |
| cmp_pwr_en_o | output | 1 | Comparator power enable |
| pos_sel_ref_o | output | 1 | Positive input taken from internal reference |
| neg_use_pin_o | output | 1 | Negative input taken from dedicated pin |
| neg_ch_o | output | 4 | Converter channel for negative input |
| neg_ch_valid_o | output | 1 | Channel selection is defined |
| pin_chg_dis_o | output | 1 | Suppress pin-change detect on comparator pins |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer, a 4-bit selector taken from a 5-bit mux field, and 11 defined channels. With these values all sixteen selector codes can be driven, so the five undefined codes and the ignored top mux bit are all exercised. The three-edge latency from input change to flag is short enough to line up edge events against same-cycle acknowledge and write-one clears. Random register writes also reach the reserved mode, and each mode change happens while edges are in flight.

// File: rtl/cmp_ctl_pkg.sv
package cmp_ctl_pkg;

    typedef enum logic [1:0] {
        MODE_TOGGLE = 2'b00,
        MODE_RSVD   = 2'b01,
        MODE_FALL   = 2'b10,
        MODE_RISE   = 2'b11
    } irq_mode_e;

    localparam int unsigned B_OFF    = 7;
    localparam int unsigned B_REF    = 6;
    localparam int unsigned B_OUT    = 5;
    localparam int unsigned B_FLAG   = 4;
    localparam int unsigned B_IE     = 3;
    localparam int unsigned B_MUXEN  = 2;
    localparam int unsigned B_MODE_H = 1;
    localparam int unsigned B_MODE_L = 0;

    typedef struct packed {
        logic      off;
        logic      refsel;
        logic      flag;
        logic      ie;
        logic      mux_en;
        irq_mode_e mode;
    } ctl_t;

endpackage

// File: rtl/cmp_ctl_sync.sv
module cmp_ctl_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o,
    output logic prev_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], d_i};
        st_d.prev  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign q_o    = st_q.chain[STAGES-1];
    assign prev_o = st_q.prev;

endmodule

// File: rtl/cmp_ctl_event.sv
module cmp_ctl_event
    import cmp_ctl_pkg::*;
(
    input  logic      cur_i,
    input  logic      prev_i,
    input  irq_mode_e mode_i,
    output logic      evt_o
);
    always_comb begin
        case (mode_i)
            MODE_TOGGLE: evt_o = cur_i ^ prev_i;
            MODE_FALL:   evt_o = prev_i & ~cur_i;
            MODE_RISE:   evt_o = cur_i & ~prev_i;
            default:     evt_o = 1'b0;
        endcase
    end

    // R4: reserved mode produces no event
    always_comb begin
        if (mode_i == MODE_RSVD) begin
            a_r4_rsvd_no_event: assert (!evt_o);
        end
    end

endmodule

// File: rtl/cmp_ctl_negsel.sv
module cmp_ctl_negsel #(
    parameter int unsigned SEL_W  = 4,
    parameter int unsigned MUX_W  = 5,
    parameter int unsigned NUM_CH = 11
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             mux_en_i,
    input  logic             adc_en_i,
    input  logic [MUX_W-1:0] adc_mux_i,
    output logic             use_pin_o,
    output logic [SEL_W-1:0] ch_o,
    output logic             ch_valid_o
);
    localparam logic [SEL_W-1:0] LAST_CH = SEL_W'(NUM_CH - 1);

    typedef struct packed {
        logic [SEL_W-1:0] sel;
    } nsel_t;

    nsel_t st_d, st_q;
    logic  path;

    generate
        if (MUX_W > SEL_W) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^adc_mux_i[MUX_W-1:SEL_W];
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        st_d.sel = adc_mux_i[SEL_W-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign path       = mux_en_i & ~adc_en_i;
    assign use_pin_o  = ~path;
    assign ch_valid_o = path & (st_q.sel <= LAST_CH);
    assign ch_o       = ch_valid_o ? st_q.sel : '0;

    logic armed_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) armed_q <= 1'b0;
        else         armed_q <= 1'b1;
    end

    a_r11_sel_one_late: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && ch_valid_o) |-> ch_o == $past(adc_mux_i[SEL_W-1:0]));

    a_r10_undef_safe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!use_pin_o && !ch_valid_o) |-> ch_o == '0);

    a_r9_pin_when_adc_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
        adc_en_i |-> (use_pin_o && !ch_valid_o));

endmodule

// File: rtl/cmp_ctl_top.sv
module cmp_ctl_top
    import cmp_ctl_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned SEL_W       = 4,
    parameter int unsigned MUX_W       = 5,
    parameter int unsigned NUM_CH      = 11
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [7:0]       wdata_i,
    output logic [7:0]       rdata_o,
    input  logic             cmp_raw_i,
    input  logic             irq_ack_i,
    input  logic             gie_i,
    output logic             irq_o,
    input  logic             adc_en_i,
    input  logic [MUX_W-1:0] adc_mux_i,
    output logic             cmp_pwr_en_o,
    output logic             pos_sel_ref_o,
    output logic             neg_use_pin_o,
    output logic [SEL_W-1:0] neg_ch_o,
    output logic             neg_ch_valid_o,
    output logic             pin_chg_dis_o
);
    ctl_t ctl_d, ctl_q;
    logic cmp_s, cmp_prev, evt, clr;

    cmp_ctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (cmp_raw_i),
        .q_o    (cmp_s),
        .prev_o (cmp_prev)
    );

    cmp_ctl_event u_event (
        .cur_i  (cmp_s),
        .prev_i (cmp_prev),
        .mode_i (ctl_q.mode),
        .evt_o  (evt)
    );

    always_comb begin
        ctl_d = ctl_q;
        clr   = irq_ack_i | (wr_en_i & wdata_i[B_FLAG]);
        if (wr_en_i) begin
            ctl_d.off    = wdata_i[B_OFF];
            ctl_d.refsel = wdata_i[B_REF];
            ctl_d.ie     = wdata_i[B_IE];
            ctl_d.mux_en = wdata_i[B_MUXEN];
            ctl_d.mode   = irq_mode_e'(wdata_i[B_MODE_H:B_MODE_L]);
        end
        if (evt)      ctl_d.flag = 1'b1;
        else if (clr) ctl_d.flag = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctl_q <= '0;
        else         ctl_q <= ctl_d;
    end

    assign rdata_o       = {ctl_q.off, ctl_q.refsel, cmp_s, ctl_q.flag,
                            ctl_q.ie, ctl_q.mux_en, ctl_q.mode};
    assign irq_o         = ctl_q.flag & ctl_q.ie & gie_i;
    assign cmp_pwr_en_o  = ~ctl_q.off;
    assign pin_chg_dis_o = ~ctl_q.off;
    assign pos_sel_ref_o = ctl_q.refsel;

    cmp_ctl_negsel #(.SEL_W(SEL_W), .MUX_W(MUX_W), .NUM_CH(NUM_CH)) u_negsel (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .mux_en_i   (ctl_q.mux_en),
        .adc_en_i   (adc_en_i),
        .adc_mux_i  (adc_mux_i),
        .use_pin_o  (neg_use_pin_o),
        .ch_o       (neg_ch_o),
        .ch_valid_o (neg_ch_valid_o)
    );

    a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt && clr) |=> rdata_o[B_FLAG]);

    a_r5_zero_write_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !wdata_i[B_FLAG] && !irq_ack_i && !evt)
        |=> rdata_o[B_FLAG] == $past(rdata_o[B_FLAG]));

    a_r4_rsvd_flag_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rdata_o[B_MODE_H:B_MODE_L] == 2'b01 && !rdata_o[B_FLAG]) |=> !rdata_o[B_FLAG]);

    a_r3_flag_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rdata_o[B_FLAG]) |-> $past(evt));

endmodule

// File: tb/cmp_ctl_top_tb_top.sv
`timescale 1ns/1ps
module cmp_ctl_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en, cmp_raw, ack, gie, adc_en;
    logic [7:0] wdata, rdata;
    logic [4:0] adc_mux;
    logic       irq, pwr, pos_ref, use_pin, ch_valid, pcd;
    logic [3:0] ch;

    int n_chk  = 0;
    int n_fail = 0;

    logic       m_s1, m_s2, m_p, m_flag, m_off, m_ref, m_ie, m_me;
    logic [1:0] m_mode;
    logic [3:0] m_sel;

    always #2 clk = ~clk;

    cmp_ctl_top dut_i (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wdata_i(wdata),
        .rdata_o(rdata), .cmp_raw_i(cmp_raw), .irq_ack_i(ack), .gie_i(gie),
        .irq_o(irq), .adc_en_i(adc_en), .adc_mux_i(adc_mux),
        .cmp_pwr_en_o(pwr), .pos_sel_ref_o(pos_ref), .neg_use_pin_o(use_pin),
        .neg_ch_o(ch), .neg_ch_valid_o(ch_valid), .pin_chg_dis_o(pcd)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic compare_all();
        logic path, valid;
        path  = m_me && !adc_en;
        valid = path && (m_sel <= 4'd10);
        chk("R2 register image", {24'd0, rdata},
            {24'd0, m_off, m_ref, m_s2, m_flag, m_ie, m_me, m_mode});
        chk("R7 interrupt request", {31'd0, irq}, {31'd0, m_flag & m_ie & gie});
        chk("R8 reference select", {31'd0, pos_ref}, {31'd0, m_ref});
        chk("R12 power and pin-change", {30'd0, pwr, pcd}, {30'd0, !m_off, !m_off});
        if (path && m_sel > 4'd10)
            chk("R10 undefined code", {26'd0, use_pin, ch_valid, ch}, {26'd0, 1'b0, 1'b0, 4'd0});
        else
            chk("R9 negative select", {26'd0, use_pin, ch_valid, ch},
                {26'd0, !path, valid, valid ? m_sel : 4'd0});
    endtask

    // Inputs are set at least 1 ns after an edge; step advances one clock
    task automatic step();
        logic evt, clr, nf;
        case (m_mode)
            2'b00:   evt = m_s2 ^ m_p;
            2'b10:   evt = m_p & ~m_s2;
            2'b11:   evt = m_s2 & ~m_p;
            default: evt = 1'b0;
        endcase
        clr = ack | (wr_en & wdata[4]);
        nf  = evt ? 1'b1 : (clr ? 1'b0 : m_flag);
        @(posedge clk);
        #1;
        m_p = m_s2; m_s2 = m_s1; m_s1 = cmp_raw;
        m_flag = nf;
        m_sel  = adc_mux[3:0];
        if (wr_en) begin
            m_off = wdata[7]; m_ref = wdata[6]; m_ie = wdata[3];
            m_me = wdata[2]; m_mode = wdata[1:0];
        end
        compare_all();
    endtask

    task automatic wr(logic [7:0] d);
        wr_en = 1'b1; wdata = d;
        step();
        wr_en = 1'b0; wdata = 8'd0;
    endtask

    task automatic set_raw_and_wait(logic v);
        cmp_raw = v;
        repeat (3) step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h00C0FFEE);
        rst_n = 1'b0; wr_en = 0; wdata = 0; cmp_raw = 0; ack = 0; gie = 0;
        adc_en = 0; adc_mux = 0;
        {m_s1, m_s2, m_p, m_flag, m_off, m_ref, m_ie, m_me} = '0;
        m_mode = 0; m_sel = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk("R1 reset register", {24'd0, rdata}, 32'd0);
        chk("R1 reset irq", {31'd0, irq}, 32'd0);
        chk("R1 reset negative select", {26'd0, use_pin, ch_valid, ch}, {26'd0, 1'b1, 1'b0, 4'd0});
        gie = 1'b1;

        // R3 toggle mode, flag appears on the third edge
        wr(8'b0000_1000);
        cmp_raw = 1'b1;
        step(); step();
        chk("R3 flag not yet set", {31'd0, rdata[4]}, 32'd0);
        step();
        chk("R3 toggle sets flag", {31'd0, rdata[4]}, 32'd1);
        chk("R7 irq with all enables", {31'd0, irq}, 32'd1);
        // R5 writing zero keeps, writing one clears
        wr(8'b0000_1000);
        chk("R5 zero write keeps flag", {31'd0, rdata[4]}, 32'd1);
        wr(8'b0001_1000);
        chk("R5 one write clears flag", {31'd0, rdata[4]}, 32'd0);
        // R3 falling mode: rising ignored
        wr(8'b0000_1010);
        set_raw_and_wait(1'b0);
        chk("R3 falling edge sets", {31'd0, rdata[4]}, 32'd1);
        ack = 1'b1; step(); ack = 1'b0;
        chk("R5 acknowledge clears", {31'd0, rdata[4]}, 32'd0);
        set_raw_and_wait(1'b1);
        chk("R3 falling mode ignores rise", {31'd0, rdata[4]}, 32'd0);
        // R3 rising mode
        wr(8'b0000_1011);
        set_raw_and_wait(1'b0);
        chk("R3 rising mode ignores fall", {31'd0, rdata[4]}, 32'd0);
        set_raw_and_wait(1'b1);
        chk("R3 rising edge sets", {31'd0, rdata[4]}, 32'd1);
        // R4 reserved mode
        wr(8'b0001_1001);
        for (int i = 0; i < 6; i++) set_raw_and_wait(~cmp_raw);
        chk("R4 reserved mode never sets", {31'd0, rdata[4]}, 32'd0);
        // R6 set and clear collide
        wr(8'b0000_1000);
        cmp_raw = ~cmp_raw;
        step(); step();
        ack = 1'b1; wr(8'b0001_1000); ack = 1'b0;
        chk("R6 set wins over clear", {31'd0, rdata[4]}, 32'd1);
        gie = 1'b0; step();
        chk("R7 irq blocked by global enable", {31'd0, irq}, 32'd0);
        gie = 1'b1;
        // R8 / R12
        wr(8'b1100_0000);
        chk("R8 reference selected", {31'd0, pos_ref}, 32'd1);
        chk("R12 comparator off", {30'd0, pwr, pcd}, 32'd0);
        // R9 / R10 all codes, top bit set
        wr(8'b0000_0100);
        for (int c = 0; c < 16; c++) begin
            adc_mux = {1'b1, 4'(c)};
            step();
        end
        adc_en = 1'b1; step();
        chk("R9 converter on uses pin", {31'd0, use_pin}, 32'd1);
        adc_en = 1'b0;
        // R11 one-cycle delay
        adc_mux = 5'd3; step();
        adc_mux = 5'd7; #0.5;
        chk("R11 old channel before edge", {28'd0, ch}, 32'd3);
        step();
        chk("R11 new channel after edge", {28'd0, ch}, 32'd7);

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(9) < 3) cmp_raw = ~cmp_raw;
            wr_en = ($urandom_range(9) < 2);
            wdata = 8'($urandom);
            ack   = ($urandom_range(9) == 0);
            if ($urandom_range(9) < 2) adc_en = ~adc_en;
            if ($urandom_range(9) < 4) adc_mux = 5'($urandom);
            gie   = ($urandom_range(9) != 0);
            step();
        end
        wr_en = 0; ack = 0;
        report();
    end
endmodule